// File: doc/BRIEF.md
# Packet Event Statistics Counters with Atomic Snapshot

This block counts six kinds of packet events on a traffic path: starts, ends and errors, each for the transmit and the receive direction. Every event arrives as a one-cycle strobe and adds one to its own wide counter. Software reads each counter as two 32-bit words through a registered read port.

Reading a wide counter as two separate words can tear if the counter moves between the two reads. To avoid this, a control register has a snapshot bit. Setting the bit copies all six counters into shadow registers in one clock edge. While the bit stays set, reads of the counter offsets return the frozen shadow values, so every word comes from the same cycle. Two further control bits clear the shadow copies and the live counters. The live counters keep counting whatever the snapshot state.

Top module: `pkt_stat_counters`

## Requirements
- R1: After synchronous reset, all six live counters, all six shadow copies and all three control bits are zero, so every read returns zero.
- R2: Event strobe bit k (0 = transmit start, 1 = transmit end, 2 = transmit error, 3 = receive start, 4 = receive end, 5 = receive error) adds exactly one to counter k on each clock edge where it is high. Strobes on different bits in the same cycle each count.
- R3: Counter k reads as its bits [31:0] at byte offset 0x20 + 8k and its bits [63:32] at 0x24 + 8k. Read data is registered and appears one clock after rd_addr is presented. Any offset that is unaligned, unmapped, or past 0x4C reads as zero.
- R4: A write to offset 0x00 loads the control register from wr_data: bit 6 = snapshot, bit 7 = clear shadows, bit 8 = clear live counters. Reading offset 0x00 returns these three bits in the same positions and zero elsewhere. All other write-data bits are ignored.
- R5: A write that takes the snapshot bit from 0 to 1 copies the values all six live counters hold before that edge into their shadows at that edge. A write that leaves the bit at 1 does not capture again.
- R6: While the snapshot bit is 1, counter offsets read the shadow copies, which do not change. While the bit is 0, they read the live counters.
- R7: While the clear-shadow bit is 1, every shadow is held at zero. This clear takes priority over a capture on the same edge.
- R8: While the clear-live bit is 1, every live counter is held at zero, even if its strobe is high.
- R9: Writes to any offset other than 0x00 change no counter, no shadow and no control bit.
- R10: Counters wrap modulo 2^CNT_W and never saturate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_strobe | input | 6 | One-cycle event pulses, one bit per counter |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Register write byte offset |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 8 | Register read byte offset |
| rd_data | output | 32 | Registered read data for the previous cycle's rd_addr |

## Verification
The bench goes after events that arrive while the snapshot is frozen. A design that read live values, or that captured again on a repeated write of the snapshot bit, would show counts that move under a set snapshot. It sets the clear-shadow and snapshot bits in one write, and sets the clear-live bit while strobes are active. A design that got the priority wrong would show nonzero shadows or counters. It also sweeps every offset, including unaligned ones and those past the last counter, writes random data to read-only offsets, and drives a narrow counter past its top value. Address decode errors, writable counters and saturating counters therefore show up as data mismatches.

// File: rtl/pkt_stat_pkg.sv
package pkt_stat_pkg;

    localparam int WORD_W   = 32;
    localparam int NUM_CNT  = 6;
    localparam int ADDR_W   = 8;
    localparam int IDX_W    = 3;
    localparam int STRIDE   = 8;

    localparam int BIT_SNAP     = 6;
    localparam int BIT_CLR_SHD  = 7;
    localparam int BIT_CLR_LIVE = 8;

    localparam logic [ADDR_W-1:0] OFFS_CTRL = 8'h00;
    localparam logic [ADDR_W-1:0] OFFS_BASE = 8'h20;
    localparam logic [ADDR_W-1:0] OFFS_LAST = ADDR_W'(32'h20 + NUM_CNT * STRIDE - 4);

    typedef enum logic [IDX_W-1:0] {
        EV_TX_START = 3'd0,
        EV_TX_END   = 3'd1,
        EV_TX_ERR   = 3'd2,
        EV_RX_START = 3'd3,
        EV_RX_END   = 3'd4,
        EV_RX_ERR   = 3'd5
    } ev_idx_e;

    typedef struct packed {
        logic clr_live;
        logic clr_shd;
        logic snap;
    } ctrl_t;

    typedef struct packed {
        logic             hit;
        logic [IDX_W-1:0] idx;
        logic             upper;
    } cnt_dec_t;

    function automatic ctrl_t ctrl_from_word(input logic [WORD_W-1:0] w);
        ctrl_t c;
        c.snap     = w[BIT_SNAP];
        c.clr_shd  = w[BIT_CLR_SHD];
        c.clr_live = w[BIT_CLR_LIVE];
        return c;
    endfunction

    function automatic logic [WORD_W-1:0] ctrl_to_word(input ctrl_t c);
        logic [WORD_W-1:0] w;
        w = '0;
        w[BIT_SNAP]     = c.snap;
        w[BIT_CLR_SHD]  = c.clr_shd;
        w[BIT_CLR_LIVE] = c.clr_live;
        return w;
    endfunction

    function automatic cnt_dec_t decode_cnt(input logic [ADDR_W-1:0] a);
        cnt_dec_t          d;
        logic [ADDR_W-1:0] off;
        d   = '0;
        off = a - OFFS_BASE;
        if (a >= OFFS_BASE && a <= OFFS_LAST && a[1:0] == 2'b00) begin
            d.hit   = 1'b1;
            d.idx   = off[IDX_W+2:3];
            d.upper = off[2];
        end
        return d;
    endfunction

endpackage

// File: rtl/pkt_stat_ctrl.sv
module pkt_stat_ctrl
    import pkt_stat_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [WORD_W-1:0] wr_data,
    output ctrl_t             ctrl_q,
    output logic              snap_take
);

    logic  wr_hit;
    ctrl_t ctrl_nxt;

    always_comb begin
        wr_hit    = wr_en && (wr_addr == OFFS_CTRL);
        ctrl_nxt  = ctrl_from_word(wr_data);
        snap_take = wr_hit && ctrl_nxt.snap && !ctrl_q.snap;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
        end else if (wr_hit) begin
            ctrl_q <= ctrl_nxt;
        end
    end

    // R9: writes to other offsets leave the control bits alone
    a_r9_ctrl_untouched: assert property (@(posedge clk) disable iff (rst)
        (!rst && wr_en && wr_addr != OFFS_CTRL) |=> $stable(ctrl_q));

    // R4: a control write, reserved bits included, loads only the three fields
    a_r4_ctrl_load: assert property (@(posedge clk) disable iff (rst)
        (!rst && wr_en && wr_addr == OFFS_CTRL) |=>
        (ctrl_to_word(ctrl_q) == ($past(wr_data) & ((32'h1 << BIT_SNAP) |
                                                   (32'h1 << BIT_CLR_SHD) |
                                                   (32'h1 << BIT_CLR_LIVE)))));

    // R5: a capture leaves the snapshot bit set
    a_r5_snap_edge: assert property (@(posedge clk) disable iff (rst)
        (!rst && snap_take) |=> ctrl_q.snap);

endmodule

// File: rtl/pkt_stat_cell.sv
module pkt_stat_cell #(
    parameter int CNT_W = 64
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ev,
    input  logic             clr_live,
    input  logic             clr_shd,
    input  logic             snap_take,
    output logic [CNT_W-1:0] live_q,
    output logic [CNT_W-1:0] shadow_q
);

    always_ff @(posedge clk) begin
        if (rst || clr_live) begin
            live_q <= '0;
        end else if (ev) begin
            live_q <= live_q + CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clr_shd) begin
            shadow_q <= '0;
        end else if (snap_take) begin
            shadow_q <= live_q;
        end
    end

    // R8: the live clear beats a strobe in the same cycle
    a_r8_clear_wins: assert property (@(posedge clk) disable iff (rst)
        (!rst && clr_live) |=> live_q == '0);

    // R2 / R10: each strobe adds exactly one, modulo the width
    a_r2_step_one: assert property (@(posedge clk) disable iff (rst)
        (!rst && !clr_live && ev) |=> live_q == $past(live_q) + CNT_W'(1));

    a_r2_idle_hold: assert property (@(posedge clk) disable iff (rst)
        (!rst && !clr_live && !ev) |=> $stable(live_q));

    // R5: the shadow takes the pre-edge live value
    a_r5_capture: assert property (@(posedge clk) disable iff (rst)
        (!rst && snap_take && !clr_shd) |=> shadow_q == $past(live_q));

    // R7: the shadow clear beats a capture
    a_r7_shadow_zero: assert property (@(posedge clk) disable iff (rst)
        (!rst && clr_shd) |=> shadow_q == '0);

    // R6: with no capture and no clear the shadow is frozen
    a_r6_shadow_frozen: assert property (@(posedge clk) disable iff (rst)
        (!rst && !snap_take && !clr_shd) |=> $stable(shadow_q));

endmodule

// File: rtl/pkt_stat_rdmux.sv
module pkt_stat_rdmux
    import pkt_stat_pkg::*;
#(
    parameter int CNT_W = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] rd_addr,
    input  ctrl_t             ctrl_q,
    input  logic [CNT_W-1:0]  live   [NUM_CNT],
    input  logic [CNT_W-1:0]  shadow [NUM_CNT],
    output logic [WORD_W-1:0] rd_data
);

    localparam int WIDE_W = 2 * WORD_W;

    cnt_dec_t          dec;
    logic [CNT_W-1:0]  sel;
    logic [WIDE_W-1:0] wide;
    logic [WORD_W-1:0] rd_nxt;

    always_comb begin
        dec = decode_cnt(rd_addr);
        sel = '0;
        for (int k = 0; k < NUM_CNT; k++) begin
            if (dec.idx == IDX_W'(k)) begin
                sel = ctrl_q.snap ? shadow[k] : live[k];
            end
        end
        wide = WIDE_W'(sel);
        if (rd_addr == OFFS_CTRL) begin
            rd_nxt = ctrl_to_word(ctrl_q);
        end else if (dec.hit) begin
            rd_nxt = dec.upper ? wide[WIDE_W-1:WORD_W] : wide[WORD_W-1:0];
        end else begin
            rd_nxt = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_data <= '0;
        end else begin
            rd_data <= rd_nxt;
        end
    end

    // R3: offsets outside the map read as zero one cycle later
    a_r3_unmapped_zero: assert property (@(posedge clk) disable iff (rst)
        (!rst && rd_addr != OFFS_CTRL && !dec.hit) |=> rd_data == '0);

endmodule

// File: rtl/pkt_stat_counters.sv
module pkt_stat_counters
    import pkt_stat_pkg::*;
#(
    parameter int CNT_W = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NUM_CNT-1:0] evt_strobe,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [WORD_W-1:0] rd_data
);

    ctrl_t            ctrl_q;
    logic             snap_take;
    logic [CNT_W-1:0] live   [NUM_CNT];
    logic [CNT_W-1:0] shadow [NUM_CNT];

    pkt_stat_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .ctrl_q    (ctrl_q),
        .snap_take (snap_take)
    );

    for (genvar k = 0; k < NUM_CNT; k++) begin : g_cell
        pkt_stat_cell #(.CNT_W(CNT_W)) u_cell (
            .clk       (clk),
            .rst       (rst),
            .ev        (evt_strobe[k]),
            .clr_live  (ctrl_q.clr_live),
            .clr_shd   (ctrl_q.clr_shd),
            .snap_take (snap_take),
            .live_q    (live[k]),
            .shadow_q  (shadow[k])
        );
    end

    pkt_stat_rdmux #(.CNT_W(CNT_W)) u_rdmux (
        .clk     (clk),
        .rst     (rst),
        .rd_addr (rd_addr),
        .ctrl_q  (ctrl_q),
        .live    (live),
        .shadow  (shadow),
        .rd_data (rd_data)
    );

    // R1: the first read after reset carries no stale data
    a_r1_reset_read: assert property (@(posedge clk)
        $fell(rst) |-> rd_data == '0);

endmodule

// File: tb/pkt_stat_counters_bench.sv
`timescale 1ns/1ps
module pkt_stat_counters_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [5:0]  evt_strobe = '0;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [7:0]  rd_addr = '0;
    logic [31:0] rd_data;

    logic [5:0]  w_ev = '0;
    logic [7:0]  w_rd_addr = 8'h20;
    logic [31:0] w_rd_data;

    always #2.5 clk = ~clk;

    pkt_stat_counters u_pkt_stat_counters (
        .clk(clk), .rst(rst), .evt_strobe(evt_strobe), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data)
    );

    pkt_stat_counters #(.CNT_W(8)) u_wrap (
        .clk(clk), .rst(rst), .evt_strobe(w_ev), .wr_en(1'b0),
        .wr_addr(8'h00), .wr_data(32'h0), .rd_addr(w_rd_addr), .rd_data(w_rd_data)
    );

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    // behavioural reference state
    longint unsigned m_live [6];
    longint unsigned m_shd  [6];
    bit m_snap, m_cshd, m_clive;
    logic [31:0] exp_rd;
    logic [7:0]  prev_ra;
    string       prev_tag;
    bit          chk_valid = 1'b0;

    function automatic logic [31:0] m_read(input logic [7:0] a);
        longint unsigned v;
        int k;
        if (a == 8'h00) return (32'(m_clive) << 8) | (32'(m_cshd) << 7) | (32'(m_snap) << 6);
        if (a >= 8'h20 && a <= 8'h4C && a[1:0] == 2'b00) begin
            k = (int'(a) - 32) / 8;
            v = m_snap ? m_shd[k] : m_live[k];
            return a[2] ? v[63:32] : v[31:0];
        end
        return 32'h0;
    endfunction

    task automatic m_step(input logic [5:0] e, input logic we, input logic [7:0] wa,
                          input logic [31:0] wd);
        bit take;
        take = we && wa == 8'h00 && wd[6] && !m_snap;
        for (int k = 0; k < 6; k++) begin
            if (m_cshd) m_shd[k] = 0;
            else if (take) m_shd[k] = m_live[k];
            if (m_clive) m_live[k] = 0;
            else if (e[k]) m_live[k] = m_live[k] + 1;
        end
        if (we && wa == 8'h00) begin
            m_snap = wd[6]; m_cshd = wd[7]; m_clive = wd[8];
        end
    endtask

    task automatic cyc(input logic [5:0] e, input logic we, input logic [7:0] wa,
                       input logic [31:0] wd, input logic [7:0] ra, input string tag);
        @(negedge clk);
        if (chk_valid) begin
            tests++;
            if (rd_data !== exp_rd) begin
                fails++;
                $display("FAIL %s addr=%02h got=%08h exp=%08h", prev_tag, prev_ra, rd_data, exp_rd);
            end
        end
        evt_strobe = e; wr_en = we; wr_addr = wa; wr_data = wd; rd_addr = ra;
        exp_rd = m_read(ra);
        m_step(e, we, wa, wd);
        prev_ra = ra; prev_tag = tag; chk_valid = 1'b1;
    endtask

    function automatic logic [7:0] cnt_addr(input int n);
        return 8'(32'h20 + (n % 12) * 4);
    endfunction

    task automatic wchk(input logic [31:0] exp, input string tag);
        repeat (2) @(negedge clk);
        tests++;
        if (w_rd_data !== exp) begin
            fails++;
            $display("FAIL %s wrap got=%08h exp=%08h", tag, w_rd_data, exp);
        end
    endtask

    initial begin
        for (int k = 0; k < 6; k++) begin m_live[k] = 0; m_shd[k] = 0; end
        m_snap = 0; m_cshd = 0; m_clive = 0;
        repeat (4) @(negedge clk);
        rst = 1'b0;

        // R1: everything zero after reset
        cyc('0, 0, 0, 0, 8'h00, "R1");
        for (int n = 0; n < 12; n++) cyc('0, 0, 0, 0, cnt_addr(n), "R1");

        // R2: random strobes, live reads
        for (int n = 0; n < 400; n++)
            cyc(6'($urandom), 0, 0, 0, cnt_addr(n), "R2");

        // R3: full offset sweep including unaligned and out-of-map offsets
        for (int a = 0; a < 96; a++) cyc('0, 0, 0, 0, 8'(a), "R3");
        cyc('0, 0, 0, 0, 8'hFC, "R3");

        // R9: writes to read-only and unmapped offsets
        for (int n = 0; n < 60; n++)
            cyc(6'($urandom), 1, 8'(4 + 4 * (n % 30)), $urandom, cnt_addr(n), "R9");
        cyc('0, 0, 0, 0, 8'h00, "R9");

        // R4: control readback, reserved bits dropped
        cyc('0, 1, 8'h00, 32'hFFFF_FE3F, 8'h00, "R4");
        cyc('0, 0, 0, 0, 8'h00, "R4");
        cyc('0, 1, 8'h00, 32'h0, 8'h00, "R4");
        cyc('0, 0, 0, 0, 8'h00, "R4");

        // R5/R6: capture, then frozen reads while strobes continue
        for (int n = 0; n < 20; n++) cyc(6'h3F, 0, 0, 0, cnt_addr(n), "R2");
        cyc(6'h3F, 1, 8'h00, 32'h40, 8'h20, "R5");
        for (int n = 0; n < 40; n++) cyc(6'($urandom), 0, 0, 0, cnt_addr(n), "R6");
        cyc(6'h15, 1, 8'h00, 32'h40, 8'h28, "R5");
        for (int n = 0; n < 24; n++) cyc(6'($urandom), 0, 0, 0, cnt_addr(n), "R5");
        cyc('0, 1, 8'h00, 32'h0, 8'h20, "R6");
        for (int n = 0; n < 24; n++) cyc(6'($urandom), 0, 0, 0, cnt_addr(n), "R6");

        // R7: shadow clear beats capture; held at zero
        cyc(6'h3F, 1, 8'h00, 32'hC0, 8'h00, "R7");
        for (int n = 0; n < 24; n++) cyc(6'($urandom), 0, 0, 0, cnt_addr(n), "R7");
        cyc('0, 1, 8'h00, 32'h40, 8'h20, "R7");
        for (int n = 0; n < 12; n++) cyc(6'($urandom), 0, 0, 0, cnt_addr(n), "R7");
        cyc('0, 1, 8'h00, 32'h0, 8'h20, "R7");
        cyc(6'h2A, 1, 8'h00, 32'h40, 8'h20, "R5");
        for (int n = 0; n < 12; n++) cyc(6'($urandom), 0, 0, 0, cnt_addr(n), "R5");
        cyc('0, 1, 8'h00, 32'h0, 8'h20, "R6");

        // R8: live clear beats strobes
        cyc(6'h3F, 1, 8'h00, 32'h100, 8'h00, "R8");
        for (int n = 0; n < 24; n++) cyc(6'h3F, 0, 0, 0, cnt_addr(n), "R8");
        cyc(6'h3F, 1, 8'h00, 32'h0, 8'h00, "R8");
        for (int n = 0; n < 24; n++) cyc(6'($urandom), 0, 0, 0, cnt_addr(n), "R8");
        cyc('0, 0, 0, 0, 8'h00, "R8");
        cyc('0, 0, 0, 0, 8'h00, "R8");

        // R10: narrow counter wraps past its top value
        @(negedge clk);
        w_ev = 6'h01;
        repeat (255) @(negedge clk);
        w_ev = '0;
        wchk(32'd255, "R10");
        w_ev = 6'h01; @(negedge clk); w_ev = '0;
        wchk(32'd0, "R10");
        w_ev = 6'h01; @(negedge clk); w_ev = '0;
        wchk(32'd1, "R10");
        w_rd_addr = 8'h24;
        wchk(32'd0, "R10");

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            tests++; fails++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule